// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block decides, every cycle, whether a five-stage in-order pipeline may advance, must insert a bubble, or must squash a wrongly fetched instruction. It looks at the source register fields of the instruction waiting in decode, the destination and control bits of the two instructions ahead of it, and the branch compare result that decode produces. From these it drives four plain control pins: a PC write enable, a decode-register write enable, a signal that forces all control bits entering execute to zero, and a signal that clears the decode register.

A bubble is made by holding the PC and the decode register, so the same instruction is fetched again on the next cycle, while execute receives all-zero controls and does nothing. Forwarding is assumed to exist elsewhere, so the only non-branch hazard left is a load followed at once by a user of the loaded register, which costs one bubble. Branches are compared in decode and fetch is predicted not taken. A taken branch therefore squashes exactly one fetched instruction. A branch cannot compare until its operands are final. If an operand comes from an ALU result still in execute, or from a load still in the memory stage, the branch is stalled instead, and the stall suppresses the flush. There is no streaming data at this block's edge, so no valid/ready handshake applies. All outputs are combinational from the inputs and the reset.

Top module: `hzd_ctrl`

## Requirements
- R1: When `idex_memrd`=1, `idex_dst`≠0 and `idex_dst` equals a source field of the decode instruction whose use flag is 1 (`dec_rs` with `dec_uses_rs`, or `dec_rt` with `dec_uses_rt`), the outputs are `pc_we`=0, `ifid_we`=0, `idex_zero`=1.
- R2: A source field whose use flag is 0 never causes a stall, and with no hazard at all the outputs are `pc_we`=1, `ifid_we`=1, `idex_zero`=0, `ifid_flush`=0.
- R3: A producer whose destination is register 0 never causes a stall.
- R4: When `dec_is_branch`=1, `idex_regwr`=1, `idex_dst`≠0 and `idex_dst` matches a used branch source, the block stalls (`pc_we`=0, `ifid_we`=0, `idex_zero`=1).
- R5: When `dec_is_branch`=1, `exmem_memrd`=1, `exmem_dst`≠0 and `exmem_dst` matches a used branch source, the block stalls. `exmem_memrd` has no effect when the decode instruction is not a branch.
- R6: A branch with ready operands and `br_taken`=1 gives `ifid_flush`=1 with `pc_we`=1, `ifid_we`=1 and `idex_zero`=0.
- R7: A branch with `br_taken`=0 gives `ifid_flush`=0.
- R8: In any cycle that stalls, `ifid_flush`=0, whatever `br_taken` is.
- R9: While `rst_n`=0 the outputs are `pc_we`=0, `ifid_we`=0, `idex_zero`=1, `ifid_flush`=0.
- R10: `br_taken` is ignored when `dec_is_branch`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the property checker |
| rst_n | input | 1 | Active-low reset; holds the pipeline frozen |
| dec_rs | input | RW | First source register of the decode instruction |
| dec_rt | input | RW | Second source register of the decode instruction |
| dec_uses_rs | input | 1 | Decode instruction reads `dec_rs` |
| dec_uses_rt | input | 1 | Decode instruction reads `dec_rt` |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| br_taken | input | 1 | Branch compare result from decode, 1 = taken |
| idex_memrd | input | 1 | Execute instruction is a load |
| idex_regwr | input | 1 | Execute instruction writes a register |
| idex_dst | input | RW | Destination register of the execute instruction |
| exmem_memrd | input | 1 | Memory-stage instruction is a load |
| exmem_dst | input | RW | Destination register of the memory-stage instruction |
| pc_we | output | 1 | PC may advance |
| ifid_we | output | 1 | Decode register may load |
| idex_zero | output | 1 | Force all controls entering execute to zero |
| ifid_flush | output | 1 | Clear the decode register |

## Verification
Directed vectors separate the three hazard sources from each other: a load matched on either source, a source match with its use flag cleared, and producers targeting register 0 show whether matching is qualified correctly. Branch cases with an ALU producer in execute, a load in the memory stage, and no producer distinguish a branch stall from a flush. The same cases taken and not taken show that the stall suppresses the flush. A load-use pair followed by its bubble cycle shows that the stall lasts one cycle. Seeded random vectors over a narrow register range then cause frequent coincidental matches across all producers at once.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic idex_zero;
    logic ifid_flush;
  } hzd_ctl_t;

  localparam int unsigned PROD_LOAD_EX  = 0;
  localparam int unsigned PROD_ALU_EX   = 1;
  localparam int unsigned PROD_LOAD_MEM = 2;
  localparam int unsigned NUM_PROD      = 3;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int unsigned RW = 5
) (
  input  logic          prod_en,
  input  logic [RW-1:0] prod_dst,
  input  logic [RW-1:0] rs,
  input  logic [RW-1:0] rt,
  input  logic          uses_rs,
  input  logic          uses_rt,
  output logic          hit
);
  logic nonzero;
  logic rs_eq, rt_eq;

  always_comb begin
    nonzero = |prod_dst;
    rs_eq   = uses_rs && (rs == prod_dst);
    rt_eq   = uses_rt && (rt == prod_dst);
    hit     = prod_en && nonzero && (rs_eq || rt_eq);
  end
endmodule

// File: rtl/hzd_resolve.sv
module hzd_resolve
  import hzd_pkg::*;
#(
  parameter int unsigned NP = NUM_PROD
) (
  input  logic          rst_n,
  input  logic [NP-1:0] hits,
  input  logic          is_branch,
  input  logic          br_taken,
  output hzd_ctl_t      ctl
);
  logic stall;
  logic redirect;

  always_comb begin
    stall    = |hits;
    redirect = is_branch && br_taken && !stall;
    if (!rst_n) begin
      ctl.pc_we      = 1'b0;
      ctl.ifid_we    = 1'b0;
      ctl.idex_zero  = 1'b1;
      ctl.ifid_flush = 1'b0;
    end else begin
      ctl.pc_we      = !stall;
      ctl.ifid_we    = !stall;
      ctl.idex_zero  = stall;
      ctl.ifid_flush = redirect;
    end
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] dec_rs,
  input  logic [RW-1:0] dec_rt,
  input  logic          dec_uses_rs,
  input  logic          dec_uses_rt,
  input  logic          dec_is_branch,
  input  logic          br_taken,
  input  logic          idex_memrd,
  input  logic          idex_regwr,
  input  logic [RW-1:0] idex_dst,
  input  logic          exmem_memrd,
  input  logic [RW-1:0] exmem_dst,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_zero,
  output logic          ifid_flush
);
  localparam int unsigned NP = NUM_PROD;

  logic          prod_en  [NP];
  logic [RW-1:0] prod_dst [NP];
  logic [NP-1:0] hits;
  hzd_ctl_t      ctl;

  // Producer table: load in execute hurts any reader; ALU result in
  // execute and load in memory stage only hurt a branch comparing in decode.
  always_comb begin
    prod_en[PROD_LOAD_EX]   = idex_memrd;
    prod_dst[PROD_LOAD_EX]  = idex_dst;
    prod_en[PROD_ALU_EX]    = dec_is_branch && idex_regwr;
    prod_dst[PROD_ALU_EX]   = idex_dst;
    prod_en[PROD_LOAD_MEM]  = dec_is_branch && exmem_memrd;
    prod_dst[PROD_LOAD_MEM] = exmem_dst;
  end

  for (genvar p = 0; p < NP; p++) begin : g_prod
    hzd_src_match #(.RW(RW)) u_match (
      .prod_en  (prod_en[p]),
      .prod_dst (prod_dst[p]),
      .rs       (dec_rs),
      .rt       (dec_rt),
      .uses_rs  (dec_uses_rs),
      .uses_rt  (dec_uses_rt),
      .hit      (hits[p])
    );
  end

  hzd_resolve #(.NP(NP)) u_resolve (
    .rst_n     (rst_n),
    .hits      (hits),
    .is_branch (dec_is_branch),
    .br_taken  (br_taken),
    .ctl       (ctl)
  );

  assign pc_we      = ctl.pc_we;
  assign ifid_we    = ctl.ifid_we;
  assign idex_zero  = ctl.idex_zero;
  assign ifid_flush = ctl.ifid_flush;
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int unsigned RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] dec_rs,
  input logic [RW-1:0] dec_rt,
  input logic          dec_uses_rs,
  input logic          dec_uses_rt,
  input logic          dec_is_branch,
  input logic          br_taken,
  input logic          idex_memrd,
  input logic          idex_regwr,
  input logic [RW-1:0] idex_dst,
  input logic          exmem_memrd,
  input logic [RW-1:0] exmem_dst,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_zero,
  input logic          ifid_flush
);
  assert_loaduse_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_memrd && (idex_dst != '0) && dec_uses_rs && (dec_rs == idex_dst))
      |-> (!pc_we && !ifid_we && idex_zero));

  assert_reg0_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((idex_dst == '0) && (exmem_dst == '0)) |-> (pc_we && !idex_zero));

  assert_branch_alu_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_is_branch && idex_regwr && (idex_dst != '0) && dec_uses_rt && (dec_rt == idex_dst))
      |-> idex_zero);

  assert_no_flush_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_is_branch && !br_taken) |-> !ifid_flush);

  assert_stall_blocks_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idex_zero |-> !ifid_flush);

  assert_flush_needs_branch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (dec_is_branch && br_taken && pc_we));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_hold_R9: assert (!pc_we && !ifid_we && idex_zero && !ifid_flush);
    end
  end
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.RW(RW)) u_chk (.*);

// File: tb/tb_hzd_ctrl.sv
`timescale 1ns/1ps
module tb_hzd_ctrl;
  localparam int unsigned RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] dec_rs = '0, dec_rt = '0, idex_dst = '0, exmem_dst = '0;
  logic dec_uses_rs = 0, dec_uses_rt = 0, dec_is_branch = 0, br_taken = 0;
  logic idex_memrd = 0, idex_regwr = 0, exmem_memrd = 0;
  logic pc_we, ifid_we, idex_zero, ifid_flush;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hzd_ctrl #(.RW(RW)) dut (.*);

  function automatic logic hit(input logic en, input logic [RW-1:0] d);
    return en && (d != '0) &&
           ((dec_uses_rs && dec_rs == d) || (dec_uses_rt && dec_rt == d));
  endfunction

  // expected {pc_we, ifid_we, idex_zero, ifid_flush}
  function automatic logic [3:0] model();
    logic st;
    if (!rst_n) return 4'b0010;
    st = hit(idex_memrd, idex_dst) ||
         hit(dec_is_branch && idex_regwr, idex_dst) ||
         hit(dec_is_branch && exmem_memrd, exmem_dst);
    return {!st, !st, st, dec_is_branch && br_taken && !st};
  endfunction

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    #2;
    got = {pc_we, ifid_we, idex_zero, ifid_flush};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic clear();
    dec_rs = 0; dec_rt = 0; dec_uses_rs = 0; dec_uses_rt = 0;
    dec_is_branch = 0; br_taken = 0; idex_memrd = 0; idex_regwr = 0;
    idex_dst = 0; exmem_memrd = 0; exmem_dst = 0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state, even with a load-use hazard present
    @(negedge clk); clear(); chk("R9 reset idle", 4'b0010);
    @(negedge clk); idex_memrd = 1; idex_dst = 3; dec_uses_rs = 1; dec_rs = 3;
    dec_is_branch = 1; br_taken = 1; chk("R9 reset with hazard", 4'b0010);
    @(negedge clk); clear(); rst_n = 1;
    chk("R2 idle after reset", 4'b1100);

    // R1 load-use on rs, then rt
    @(negedge clk); clear(); idex_memrd = 1; idex_regwr = 1; idex_dst = 7;
    dec_uses_rs = 1; dec_rs = 7; dec_uses_rt = 1; dec_rt = 2;
    chk("R1 load-use rs", 4'b0010);
    // following cycle: bubble in execute, load in memory stage
    @(negedge clk); idex_memrd = 0; idex_regwr = 0; idex_dst = 0;
    exmem_memrd = 1; exmem_dst = 7;
    chk("R1 single stall then advance", 4'b1100);
    @(negedge clk); clear(); idex_memrd = 1; idex_dst = 9;
    dec_uses_rt = 1; dec_rt = 9; dec_rs = 1; dec_uses_rs = 1;
    chk("R1 load-use rt", 4'b0010);
    // R2 field unused
    @(negedge clk); dec_uses_rt = 0;
    chk("R2 rt unused", 4'b1100);
    @(negedge clk); dec_uses_rt = 1; dec_rt = 8;
    chk("R2 no match", 4'b1100);
    // R3 register zero
    @(negedge clk); clear(); idex_memrd = 1; idex_dst = 0;
    dec_uses_rs = 1; dec_uses_rt = 1;
    chk("R3 load to r0", 4'b1100);
    @(negedge clk); dec_is_branch = 1; idex_memrd = 0; idex_regwr = 1;
    exmem_memrd = 1; br_taken = 1;
    chk("R3 branch r0 producers", 4'b1101);
    // R4 branch waits for ALU result in execute
    @(negedge clk); clear(); dec_is_branch = 1; dec_uses_rs = 1; dec_uses_rt = 1;
    dec_rs = 4; dec_rt = 5; idex_regwr = 1; idex_dst = 5; br_taken = 0;
    chk("R4 branch alu wait", 4'b0010);
    // R8 same with taken compare: stall wins, no flush
    @(negedge clk); br_taken = 1;
    chk("R8 stall suppresses flush", 4'b0010);
    // R4 contrast: non-branch with ALU producer does not stall
    @(negedge clk); dec_is_branch = 0;
    chk("R4 alu producer non-branch", 4'b1100);
    // R5 branch waits for load in memory stage
    @(negedge clk); clear(); dec_is_branch = 1; dec_uses_rs = 1; dec_rs = 6;
    exmem_memrd = 1; exmem_dst = 6; br_taken = 1;
    chk("R5 branch mem load wait", 4'b0010);
    @(negedge clk); dec_is_branch = 0; br_taken = 0;
    chk("R5 mem load non-branch ignored", 4'b1100);
    // R6 taken with ready operands
    @(negedge clk); clear(); dec_is_branch = 1; dec_uses_rs = 1; dec_rs = 6;
    exmem_memrd = 0; exmem_dst = 6; idex_regwr = 1; idex_dst = 2; br_taken = 1;
    chk("R6 taken flush", 4'b1101);
    // R7 not taken
    @(negedge clk); br_taken = 0;
    chk("R7 not taken", 4'b1100);
    // R10 br_taken ignored for non-branch
    @(negedge clk); clear(); br_taken = 1; dec_uses_rs = 1; dec_rs = 3;
    chk("R10 taken without branch", 4'b1100);

    // random mix, narrow register range for frequent matches
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      dec_rs = RW'($urandom_range(0, 3)); dec_rt = RW'($urandom_range(0, 3));
      idex_dst = RW'($urandom_range(0, 3)); exmem_dst = RW'($urandom_range(0, 3));
      {dec_uses_rs, dec_uses_rt, dec_is_branch, br_taken} = 4'($urandom);
      {idex_memrd, idex_regwr, exmem_memrd} = 3'($urandom);
      chk("R1/R4/R5/R6/R8 random", model());
    end

    // R9 reset re-entry
    @(negedge clk); rst_n = 0; chk("R9 reset reassert", 4'b0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule